// File: doc/BRIEF.md
# R-format execution unit with register file and Hi/Lo pair

This block executes one register-to-register instruction word per clock. The word is presented directly on an input port, so there is no fetch logic, program counter or data memory around it. The unit decodes the word's fields and reads two source operands from a 32 x 32-bit register file. It computes the result combinationally and drives it on an output during the same cycle. On the next rising edge it writes that result into the destination register.

A separate Hi/Lo register pair holds the 64-bit results of multiply and divide. Two move instructions bring either half back into the register file. Words the unit does not support are flagged on an output during the cycle they are presented, and they leave all state untouched. Software builds constants with the unit's own instructions, because only reset can load values from outside.

Top module: `rtype_exec`

## Requirements
- R1: The instruction word is decoded as opcode [31:26], source A register [25:21], source B register [20:16], destination register [15:11], shift amount [10:6] and function code [5:0]. Only words with opcode 0 are candidates for execution.
- R2: For every result-producing instruction, `result` shows the computed value during the cycle the word is present. The same value is written into the destination register on the next rising clock edge, so a later instruction reads it back.
- R3: Register 0 always reads as zero. An instruction whose destination is register 0 still drives its value on `result`, but it changes no state.
- R4: Shifts act on source B by the shift amount: function 00h is logical left, 02h is logical right and 03h is arithmetic right.
- R5: The arithmetic and logic operations are selected by function code: 20h add, 21h addu, 22h sub, 23h subu, 24h and, 25h or, 27h nor, and 2Bh unsigned set-less-than (1 or 0). Add and sub wrap modulo 2^32 with no exception, just like addu and subu.
- R6: Function 18h (signed) and 19h (unsigned) multiply A by B. The upper 32 bits of the 64-bit product go to Hi and the lower 32 bits go to Lo.
- R7: Function 1Ah (signed, truncating) and 1Bh (unsigned) divide A by B. The quotient goes to Lo and the remainder goes to Hi. When B is zero, Hi and Lo keep their values.
- R8: Function 10h copies Hi into the destination register, and function 12h copies Lo into it.
- R9: The multiply and divide functions (18h-1Bh) never write the register file, whatever the destination field holds, and they drive `result` to zero.
- R10: A word with a non-zero opcode, or with a function code outside those listed in R4-R9 (including 08h and 2Ah), raises `illegal` during that cycle and drives `result` to zero. It writes neither the register file nor Hi/Lo.
- R11: A synchronous reset, sampled on the rising edge while `rst` is high, clears every register, Hi and Lo to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word executed this cycle |
| result | output | 32 | Combinational result of the current word (zero for multiply, divide and unsupported words) |
| illegal | output | 1 | High while the current word is unsupported |

## Verification
The checks assume that `instr` is stable from one falling edge through the following rising edge, and that `rst` is high for the first clock edge, so Hi and Lo start from a known value. They also assume that no signed divide of the most negative value by -1 is presented, because that quotient cannot be represented. The bench changes inputs only on falling edges and asserts reset before any instruction. It builds every operand from register-file contents, using nor, sub and shifts, and it chooses divide operands that stay clear of the overflow case.

// File: rtl/rtype_exec.sv
module rtype_exec (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  output logic [31:0] result,
  output logic        illegal
);
  localparam int NREG = 32;

  logic [31:0] rf [NREG];
  logic [31:0] hi, lo;

  wire [5:0] op    = instr[31:26];
  wire [4:0] rs    = instr[25:21];
  wire [4:0] rt    = instr[20:16];
  wire [4:0] rd    = instr[15:11];
  wire [4:0] sh    = instr[10:6];
  wire [5:0] funct = instr[5:0];

  wire [31:0] opa = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] opb = (rt == 5'd0) ? 32'd0 : rf[rt];

  wire signed [63:0] smul = $signed({{32{opa[31]}}, opa}) * $signed({{32{opb[31]}}, opb});
  wire        [63:0] umul = {32'd0, opa} * {32'd0, opb};

  logic [31:0] alu, nhi, nlo;
  logic        bad, wr_rd, wr_hl;

  always_comb begin
    alu   = '0;
    nhi   = hi;
    nlo   = lo;
    bad   = 1'b0;
    wr_rd = 1'b1;
    wr_hl = 1'b0;
    case (funct)
      6'h00: alu = opb << sh;
      6'h02: alu = opb >> sh;
      6'h03: alu = $signed(opb) >>> sh;
      6'h10: alu = hi;
      6'h12: alu = lo;
      6'h18: begin wr_rd = 1'b0; wr_hl = 1'b1; {nhi, nlo} = smul; end
      6'h19: begin wr_rd = 1'b0; wr_hl = 1'b1; {nhi, nlo} = umul; end
      6'h1A: begin
        wr_rd = 1'b0;
        if (opb != 32'd0) begin
          wr_hl = 1'b1;
          nlo = $signed(opa) / $signed(opb);
          nhi = $signed(opa) % $signed(opb);
        end
      end
      6'h1B: begin
        wr_rd = 1'b0;
        if (opb != 32'd0) begin
          wr_hl = 1'b1;
          nlo = opa / opb;
          nhi = opa % opb;
        end
      end
      6'h20, 6'h21: alu = opa + opb;
      6'h22, 6'h23: alu = opa - opb;
      6'h24: alu = opa & opb;
      6'h25: alu = opa | opb;
      6'h27: alu = ~(opa | opb);
      6'h2B: alu = {31'd0, opa < opb};
      default: begin bad = 1'b1; wr_rd = 1'b0; end
    endcase
  end

  assign illegal = (op != 6'd0) || bad;
  assign result  = illegal ? 32'd0 : alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      hi <= '0;
      lo <= '0;
    end else if (!illegal) begin
      if (wr_rd && rd != 5'd0) rf[rd] <= alu;
      if (wr_hl) begin
        hi <= nhi;
        lo <= nlo;
      end
    end
  end
endmodule

module rtype_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] result,
  input logic        illegal,
  input logic [31:0] hi,
  input logic [31:0] lo,
  input logic [31:0] opb
);
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> result == 32'd0);

  p_illegal_hilo_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |=> ($stable(hi) && $stable(lo)));

  p_r0_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd0 && instr[25:16] == 10'd0 && instr[5:0] == 6'h25) |-> result == 32'd0);

  p_muldiv_no_result_r9: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd0 && instr[5:2] == 4'b0110) |-> result == 32'd0);

  p_divzero_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd0 && instr[5:1] == 5'b01101 && opb == 32'd0) |=> ($stable(hi) && $stable(lo)));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (hi == 32'd0 && lo == 32'd0));
endmodule

bind rtype_exec rtype_exec_chk u_chk (.*);

// File: tb/rtype_exec_bench.sv
module rtype_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtype_exec u_rtype_exec (.clk(clk), .rst(rst), .instr(instr), .result(result), .illegal(illegal));

  function automatic logic [31:0] enc(input int rs, input int rt, input int rd, input int sh, input int fn);
    logic [31:0] w;
    w = {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    return w;
  endfunction

  localparam int NV = 48;
  // {requirement number, instruction, expected result, expected illegal}
  localparam logic [68:0] VEC [NV] = '{
    {4'd5,  enc(0,0,1,0,8'h27),  32'hFFFFFFFF, 1'b0}, // R5 nor
    {4'd5,  enc(0,1,2,0,8'h22),  32'h00000001, 1'b0}, // R5 sub
    {4'd4,  enc(0,2,3,4,8'h00),  32'h00000010, 1'b0}, // R4 sll
    {4'd2,  enc(3,2,4,0,8'h20),  32'h00000011, 1'b0}, // R2 add reads written regs
    {4'd4,  enc(0,1,5,28,8'h02), 32'h0000000F, 1'b0}, // R4 srl
    {4'd4,  enc(0,2,6,31,8'h00), 32'h80000000, 1'b0}, // R4 sll by 31
    {4'd4,  enc(0,6,7,4,8'h03),  32'hF8000000, 1'b0}, // R4 sra negative
    {4'd4,  enc(0,6,8,4,8'h02),  32'h08000000, 1'b0}, // R4 srl negative
    {4'd5,  enc(4,5,9,0,8'h24),  32'h00000001, 1'b0}, // R5 and
    {4'd5,  enc(3,5,10,0,8'h25), 32'h0000001F, 1'b0}, // R5 or
    {4'd5,  enc(2,3,11,0,8'h23), 32'hFFFFFFF1, 1'b0}, // R5 subu
    {4'd5,  enc(2,3,12,0,8'h2B), 32'h00000001, 1'b0}, // R5 sltu true
    {4'd5,  enc(1,2,13,0,8'h2B), 32'h00000000, 1'b0}, // R5 sltu unsigned compare
    {4'd5,  enc(1,2,14,0,8'h21), 32'h00000000, 1'b0}, // R5 addu wrap
    {4'd5,  enc(6,6,17,0,8'h20), 32'h00000000, 1'b0}, // R5 add wraps, no exception
    {4'd2,  enc(17,7,18,0,8'h21),32'hF8000000, 1'b0}, // R2 wrapped add was written
    {4'd6,  enc(11,3,0,0,8'h18), 32'h00000000, 1'b0}, // R6 mult signed
    {4'd8,  enc(0,0,15,0,8'h10), 32'hFFFFFFFF, 1'b0}, // R8 mfhi
    {4'd8,  enc(0,0,16,0,8'h12), 32'hFFFFFF10, 1'b0}, // R8 mflo
    {4'd6,  enc(1,1,0,0,8'h19),  32'h00000000, 1'b0}, // R6 multu
    {4'd6,  enc(0,0,15,0,8'h10), 32'hFFFFFFFE, 1'b0}, // R6 multu hi
    {4'd6,  enc(0,0,16,0,8'h12), 32'h00000001, 1'b0}, // R6 multu lo
    {4'd7,  enc(11,3,0,0,8'h1A), 32'h00000000, 1'b0}, // R7 div signed
    {4'd7,  enc(0,0,15,0,8'h12), 32'h00000000, 1'b0}, // R7 quotient
    {4'd7,  enc(0,0,15,0,8'h10), 32'hFFFFFFF1, 1'b0}, // R7 remainder
    {4'd7,  enc(4,5,0,0,8'h1B),  32'h00000000, 1'b0}, // R7 divu
    {4'd7,  enc(0,0,15,0,8'h12), 32'h00000001, 1'b0}, // R7 quotient
    {4'd7,  enc(0,0,15,0,8'h10), 32'h00000002, 1'b0}, // R7 remainder
    {4'd7,  enc(4,0,0,0,8'h1A),  32'h00000000, 1'b0}, // R7 divide by zero
    {4'd7,  enc(0,0,15,0,8'h12), 32'h00000001, 1'b0}, // R7 lo kept
    {4'd7,  enc(0,0,15,0,8'h10), 32'h00000002, 1'b0}, // R7 hi kept
    {4'd10, enc(4,0,0,0,8'h08),  32'h00000000, 1'b1}, // R10 function 08h
    {4'd10, enc(1,2,20,0,8'h2A), 32'h00000000, 1'b1}, // R10 function 2Ah
    {4'd10, enc(20,0,21,0,8'h21),32'h00000000, 1'b0}, // R10 reg 20 untouched
    {4'd10, enc(1,20,0,0,8'h20) | 32'h20000000, 32'h00000000, 1'b1}, // R10 opcode 8
    {4'd10, enc(20,0,21,0,8'h21),32'h00000000, 1'b0}, // R10 reg 20 untouched
    {4'd10, enc(0,0,21,0,8'h10), 32'h00000002, 1'b0}, // R10 hi untouched
    {4'd3,  enc(0,0,0,0,8'h27),  32'hFFFFFFFF, 1'b0}, // R3 write to reg 0
    {4'd3,  enc(0,0,22,0,8'h21), 32'h00000000, 1'b0}, // R3 reg 0 still zero
    {4'd9,  enc(4,5,23,0,8'h18), 32'h00000000, 1'b0}, // R9 mult with rd field 23
    {4'd9,  enc(23,0,24,0,8'h21),32'h00000000, 1'b0}, // R9 reg 23 not written
    {4'd8,  enc(0,0,24,0,8'h12), 32'h000000FF, 1'b0}, // R8 mflo 17*15
    {4'd1,  enc(3,5,31,0,8'h25), 32'h0000001F, 1'b0}, // R1 top rd index
    {4'd1,  enc(31,0,30,0,8'h21),32'h0000001F, 1'b0}, // R1 rs field reads reg 31
    {4'd4,  enc(0,4,25,1,8'h03), 32'h00000008, 1'b0}, // R4 sra positive
    {4'd6,  enc(1,1,0,0,8'h18),  32'h00000000, 1'b0}, // R6 mult (-1)*(-1)
    {4'd6,  enc(0,0,25,0,8'h10), 32'h00000000, 1'b0}, // R6 signed hi zero
    {4'd10, enc(1,2,3,0,8'h26),  32'h00000000, 1'b1}  // R10 unlisted function 26h
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11 illegal after reset", {31'd0, illegal}, 32'd0);
    step(enc(0,0,26,0,8'h12));
    check("R11 lo cleared", result, 32'd0);
    step(enc(0,0,26,0,8'h10));
    check("R11 hi cleared", result, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][64:33]);
      check($sformatf("R%0d vec %0d result", VEC[i][68:65], i), result, VEC[i][32:1]);
      check($sformatf("R%0d vec %0d illegal", VEC[i][68:65], i), {31'd0, illegal}, {31'd0, VEC[i][0]});
    end

    @(negedge clk);
    rst = 1'b1;
    instr = 32'd0;
    @(negedge clk);
    rst = 1'b0;
    step(enc(4,0,26,0,8'h21));
    check("R11 reg 4 cleared", result, 32'd0);
    step(enc(31,0,26,0,8'h21));
    check("R11 reg 31 cleared", result, 32'd0);
    step(enc(0,0,26,0,8'h12));
    check("R11 lo cleared again", result, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule